// File: doc/BRIEF.md
# Match-Compare System Timer with Watchdog

This peripheral keeps one 32-bit up-counter that advances by one on every cycle where the tick-enable input is high. It also holds four 32-bit compare values, one per channel. When a tick carries the counter onto a channel's compare value, that channel's sticky flag is raised. A per-channel enable mask passes the flags to four interrupt lines. Software acknowledges an event by writing ones to the flag register. It schedules the next event by writing a new compare value, usually the current count plus an interval.

Channel 3 can also serve as a watchdog. Once software arms it, it stays armed until reset. From then on, every channel 3 event also drives a one-cycle pulse on a system reset output. The register interface is a single-cycle select/write strobe with a word index. Reads are combinational on the same cycle.

Top module: `os_match_timer`

## Requirements
- R1: After reset, all eight words read as zero, irq_o is 0 and wdt_rst_o is 0.
- R2: Words 0 to 3 hold the compare values of channels 0 to 3, and each reads back what was last written to it.
- R3: Word 4 is the counter. A write loads the written value, and that load takes priority over a tick. Each tick_en cycle otherwise adds one, wrapping from 0xFFFFFFFF to 0, and the counter holds when tick_en is low.
- R4: Word 5 bit i is the flag of channel i. It sets on the edge where a tick moves the counter onto that channel's compare value, whether or not the channel is enabled.
- R5: Word 6 bits 3:0 are the enable mask. irq_o[i] is high exactly while flag i and enable bit i are both 1.
- R6: Writing word 5 clears each flag whose bit in the written value is 1. Flags written as 0 keep their value.
- R7: Loading the counter with a channel's compare value through word 4 does not set that channel's flag.
- R8: When a flag-setting event and a write that clears the same flag fall on one edge, the flag ends set.
- R9: While the watchdog is not armed, a channel 3 event sets flag 3 and leaves wdt_rst_o low.
- R10: Word 7 bit 0 is the watchdog arm bit. Writing 1 arms it. Writing 0 leaves it armed, and it clears only on reset.
- R11: With the watchdog armed, a channel 3 event makes wdt_rst_o high for exactly one cycle, on the same edge as the flag sets.
- R12: Clearing flag 0 and writing word 0 with the current count plus N makes irq_o[0] rise again after exactly N more ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| tick_en | input | 1 | Counter advance strobe |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 4 | Per-channel interrupt lines |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two things can land on the same clock edge: a tick that sets a channel's flag, and a software write that clears that flag. The bench provokes this deliberately. It preloads the counter one below channel 1's compare value, then drives a flag-1 clear write and a tick in the same cycle. A later read of the flag register must show flag 1 still set, and irq_o[1] must be high. A design that let the clear win would read zero there.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam int DW     = 32;
  localparam int NCH    = 4;
  localparam int AW     = 3;
  localparam int WDG_CH = NCH - 1;

  typedef enum logic [AW-1:0] {
    REG_CMP0  = 3'd0,
    REG_CMP1  = 3'd1,
    REG_CMP2  = 3'd2,
    REG_CMP3  = 3'd3,
    REG_COUNT = 3'd4,
    REG_FLAG  = 3'd5,
    REG_MASK  = 3'd6,
    REG_WDOG  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load_we,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count_q,
  output logic          step_o,
  output logic [DW-1:0] count_inc_o
);
  logic [DW-1:0] count_d;
  logic          count_ce;

  always_comb begin
    count_inc_o = count_q + {{(DW-1){1'b0}}, 1'b1};
    step_o      = tick_en && !load_we;
    count_ce    = load_we || tick_en;
    count_d     = load_we ? load_val : count_inc_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_ce) count_q <= count_d;
  end

  // R3: a tick without a load advances by exactly one, modulo 2^DW
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_we) |=> (count_q == $past(count_q) + 1'b1));
  // R3: no tick and no load keeps the count
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_we) |=> $stable(count_q));
endmodule

// File: rtl/ost_match_chan.sv
module ost_match_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic [DW-1:0] count_inc,
  input  logic          clr_we,
  input  logic          clr_bit,
  input  logic          en_bit,
  output logic [DW-1:0] cmp_q,
  output logic          flag_q,
  output logic          hit_o,
  output logic          irq_o
);
  logic flag_d;

  always_comb begin
    hit_o  = step && (count_inc == cmp_q);
    flag_d = flag_q;
    if (clr_we && clr_bit) flag_d = 1'b0;
    if (hit_o)             flag_d = 1'b1;   // a new event outranks the clear
    irq_o  = flag_q && en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R4: an event always leaves the flag set
  p_hit_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> flag_q);
  // R6: a set flag survives unless its bit is written as one
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(clr_we && clr_bit)) |=> flag_q);
endmodule

// File: rtl/ost_watchdog.sv
module ost_watchdog (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_we,
  input  logic arm_bit,
  input  logic hit,
  output logic armed_q,
  output logic rst_pulse_q
);
  logic armed_d;
  logic pulse_d;

  always_comb begin
    armed_d = armed_q || (arm_we && arm_bit);
    pulse_d = armed_q && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      armed_q     <= armed_d;
      rst_pulse_q <= pulse_d;
    end
  end

  // R10: once armed, stays armed until reset
  p_arm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R11: the reset pulse lasts one cycle
  p_pulse_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_q |=> !rst_pulse_q);
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import ost_pkg::*;
#(
  parameter int DATA_W = ost_pkg::DW,
  parameter int N_CH   = ost_pkg::NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   irq_o,
  output logic              wdt_rst_o
);
  localparam int WCH = N_CH - 1;

  logic                         wr_en;
  logic                         cnt_we, flag_we, mask_we, wdog_we;
  logic [N_CH-1:0]              cmp_we;
  logic [DATA_W-1:0]            count_q, count_inc;
  logic                         step;
  logic [N_CH-1:0][DATA_W-1:0]  cmp_q;
  logic [N_CH-1:0]              flag_q, hit, mask_q, mask_d;
  logic                         armed_q;

  always_comb begin
    wr_en   = bus_sel && bus_wr;
    cnt_we  = wr_en && (bus_addr == REG_COUNT);
    flag_we = wr_en && (bus_addr == REG_FLAG);
    mask_we = wr_en && (bus_addr == REG_MASK);
    wdog_we = wr_en && (bus_addr == REG_WDOG);
    mask_d  = mask_we ? bus_wdata[N_CH-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  ost_counter #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load_we(cnt_we), .load_val(bus_wdata),
    .count_q(count_q), .step_o(step), .count_inc_o(count_inc)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign cmp_we[g] = wr_en && (bus_addr == AW'(g));
    ost_match_chan #(.DW(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we[g]), .wdata(bus_wdata),
      .step(step), .count_inc(count_inc),
      .clr_we(flag_we), .clr_bit(bus_wdata[g]), .en_bit(mask_q[g]),
      .cmp_q(cmp_q[g]), .flag_q(flag_q[g]), .hit_o(hit[g]), .irq_o(irq_o[g])
    );
  end

  ost_watchdog u_wdg (
    .clk(clk), .rst_n(rst_n), .arm_we(wdog_we), .arm_bit(bus_wdata[0]),
    .hit(hit[WCH]), .armed_q(armed_q), .rst_pulse_q(wdt_rst_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_COUNT: bus_rdata = count_q;
      REG_FLAG:  bus_rdata[N_CH-1:0] = flag_q;
      REG_MASK:  bus_rdata[N_CH-1:0] = mask_q;
      REG_WDOG:  bus_rdata[0] = armed_q;
      default:   bus_rdata = cmp_q[bus_addr[1:0]];
    endcase
  end

  // R11: the reset pulse follows a channel 3 event only while the watchdog is armed
  p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> flag_q[WCH]);
  // R5: an interrupt line implies its mask bit is set
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> mask_q[0]);
endmodule

// File: tb/os_match_timer_tb.sv
module os_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;
  logic        wdt_rst_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [31:0] exp; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  os_match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the front of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (bus_sel && !bus_wr) begin
        if (sb_q.size() == 0) check("scoreboard-empty", 32'h1, 32'h0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          check(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic idle();
    @(posedge clk); #2;
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit tk = 1'b0);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    idle();
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    sb_q.push_back('{tag: tag, exp: exp});
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    idle();
  endtask

  task automatic tick(input int n);
    @(posedge clk); #2;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #2 tick_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog timeout act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    check("R1 irq", {28'd0, irq_o}, 32'd0);
    check("R1 wdt", {31'd0, wdt_rst_o}, 32'd0);
    for (int i = 0; i < 8; i++) rd(3'(i), 32'd0, "R1 reg reset");
    // R2: compare registers
    wr(3'd0, 32'd10); wr(3'd1, 32'd20); wr(3'd2, 32'hDEADBEEF); wr(3'd3, 32'd64);
    rd(3'd0, 32'd10, "R2 cmp0"); rd(3'd1, 32'd20, "R2 cmp1");
    rd(3'd2, 32'hDEADBEEF, "R2 cmp2"); rd(3'd3, 32'd64, "R2 cmp3");
    // R3: load, count, wrap
    wr(3'd4, 32'd100); tick(5); rd(3'd4, 32'd105, "R3 count");
    wr(3'd4, 32'hFFFFFFFF); tick(1); rd(3'd4, 32'd0, "R3 wrap");
    // R4: event sets flag with mask off
    wr(3'd4, 32'd5); tick(5);
    rd(3'd5, 32'h1, "R4 flag0 set");
    check("R4 irq masked", {28'd0, irq_o}, 32'd0);
    // R7: load onto compare value sets nothing new
    wr(3'd4, 32'd20); rd(3'd5, 32'h1, "R7 load no flag");
    // R5: mask
    wr(3'd6, 32'hF); rd(3'd6, 32'hF, "R5 mask read");
    check("R5 irq0", {28'd0, irq_o}, 32'h1);
    // R6: write-one-to-clear
    wr(3'd5, 32'h2); rd(3'd5, 32'h1, "R6 zero bits keep");
    wr(3'd5, 32'h1); rd(3'd5, 32'h0, "R6 cleared");
    check("R6 irq low", {28'd0, irq_o}, 32'd0);
    // R8: event and clear on the same edge
    wr(3'd4, 32'd19);
    wr(3'd5, 32'h2, 1'b1);
    rd(3'd5, 32'h2, "R8 set wins");
    check("R8 irq1", {28'd0, irq_o}, 32'h2);
    wr(3'd5, 32'h2);
    // R9: unarmed channel 3 event
    wr(3'd4, 32'd63); tick(1);
    check("R9 no reset", {31'd0, wdt_rst_o}, 32'd0);
    rd(3'd5, 32'h8, "R9 flag3");
    wr(3'd5, 32'h8);
    // R10: arm is sticky
    wr(3'd7, 32'h1); rd(3'd7, 32'h1, "R10 armed");
    wr(3'd7, 32'h0); rd(3'd7, 32'h1, "R10 zero ignored");
    // R11: one-cycle reset pulse
    wr(3'd4, 32'd63); tick(1);
    check("R11 pulse high", {31'd0, wdt_rst_o}, 32'd1);
    @(posedge clk); #2;
    check("R11 pulse ends", {31'd0, wdt_rst_o}, 32'd0);
    rd(3'd5, 32'h8, "R11 flag3");
    wr(3'd5, 32'h8);
    // R12: reschedule channel 0 at count + 7
    rd(3'd4, 32'd64, "R12 count now");
    wr(3'd5, 32'h1); wr(3'd0, 32'd71);
    tick(6);
    check("R12 not yet", {28'd0, irq_o}, 32'd0);
    tick(1);
    check("R12 irq0 again", {28'd0, irq_o}, 32'h1);
    rd(3'd4, 32'd71, "R12 count");
    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) check("scoreboard-drain", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule